// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR-style flash. After software has started an embedded program or erase operation, it pulses `start`. The poller then reads the device's status word over a simple request/acknowledge bus. It decides whether the operation finished, finished late, or failed. It finishes by raising `done`, with `fail` showing the result.

**Polling pairs.** Completion is judged by reading the status word twice in a row and comparing the toggle bit (bit 6) between the two reads. A toggle bit that holds still means the operation has ended. A toggle bit that flips means the operation is still running. In that case the limit-exceeded flag (bit 5) of the second read decides what happens next:

- **Bit 5 clear:** another pair of reads follows.
- **Bit 5 set:** one more confirming pair is read. This tells an operation that stopped just as the flag rose apart from a real failure.

**Failure and abort.** On a real failure, the poller writes the reset command `0xF0`. This returns the device to array reads before the poller reports. A host-programmed limit on the number of toggling pairs gives up on a device that never settles. The host may abandon polling with `abort`. A later `start` always begins with a fresh pair of reads.

Top module: `flash_toggle_poller`

## Requirements
- R1: After reset, `bus_req`, `done` and `fail` are 0 and the block is idle.
- R2: Each check reads the status word twice at the address captured from `status_addr` at start. If bit 6 is equal in both reads, the block sets `done`=1 and `fail`=0 and stops requesting.
- R3: If bit 6 differs between the two reads and bit 5 of the second read is 0, a new pair of reads follows.
- R4: If bit 6 differs and bit 5 of the second read is 1, a confirming pair of reads follows. If bit 6 is equal across the confirming pair, the result is success with no reset write.
- R5: If bit 6 still differs in the confirming pair, the block issues one write of `0xF0` (`bus_we`=1). After that write is acknowledged, it sets `done`=1 and `fail`=1.
- R6: Once the number of toggling pairs with bit 5 clear reaches `max_polls`, the block takes the failure path of R5. A `max_polls` of 0 is treated as 1.
- R7: `abort` while busy drops `bus_req` in the next cycle and returns to idle without setting `done`. The next `start` begins with a new pair of reads and reuses no earlier sample.
- R8: `done` and `fail` keep their values until the next accepted `start`, which clears both.
- R9: A request keeps `bus_req`, `bus_addr`, `bus_we` and `bus_wdata` steady until the cycle in which `bus_ack` is high (or `abort` ends it). A transfer completes in a cycle where `bus_req` and `bus_ack` are both high.
- R10: `start` is ignored while a check is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new completion check (accepted only when idle) |
| abort | input | 1 | Abandon the check in progress |
| status_addr | input | ADDR_W | Address used for status reads, captured at start |
| max_polls | input | CNT_W | Limit on toggling pairs with bit 5 clear, captured at start |
| bus_req | output | 1 | Bus request, held until acknowledged |
| bus_we | output | 1 | 1 for the reset-command write, 0 for status reads |
| bus_addr | output | ADDR_W | Request address |
| bus_wdata | output | DATA_W | Write data (the reset command during a write) |
| bus_rdata | input | DATA_W | Read data, valid in the acknowledge cycle |
| bus_ack | input | 1 | Transfer acknowledge |
| done | output | 1 | Check finished; held until the next start |
| fail | output | 1 | Check finished in failure; held until the next start |

## Verification
The assertions assume a well-behaved bus: `bus_ack` is raised only while `bus_req` is high. They also assume the host sends `abort` only as a short pulse. The bench flash model honours both rules. It acknowledges a pending request on every other cycle and returns a status word whose bit 6 flips after each accepted read, for a programmed number of reads. The host model pulses `start` and `abort` for exactly one cycle and changes `status_addr` and `max_polls` only while the block is idle.

// File: rtl/flash_toggle_poller.sv
`timescale 1ns/1ps
module flash_toggle_poller #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 8,
  parameter int CNT_W = 16,
  parameter int TOG_BIT = 6,
  parameter int LIM_BIT = 5,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic [ADDR_W-1:0] status_addr,
  input  logic [CNT_W-1:0]  max_polls,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              done,
  output logic              fail
);

  typedef enum logic [2:0] {S_IDLE, S_RD1, S_RD2, S_CF1, S_CF2, S_RST} state_t;

  state_t            state;
  logic              first_tog;
  logic [CNT_W-1:0]  polls, max_q;
  logic [ADDR_W-1:0] addr_q;

  wire xfer    = bus_req & bus_ack & ~abort;
  wire toggled = bus_rdata[TOG_BIT] ^ first_tog;
  wire limit   = ({1'b0, polls} + 1'b1) >= {1'b0, max_q};

  assign bus_req   = (state != S_IDLE);
  assign bus_we    = (state == S_RST);
  assign bus_addr  = bus_we ? '0 : addr_q;
  assign bus_wdata = bus_we ? RESET_CMD : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      first_tog <= 1'b0;
      polls     <= '0;
      max_q     <= '0;
      addr_q    <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else if (state == S_IDLE) begin
      if (start) begin
        state  <= S_RD1;
        done   <= 1'b0;
        fail   <= 1'b0;
        polls  <= '0;
        max_q  <= (max_polls == '0) ? CNT_W'(1) : max_polls;
        addr_q <= status_addr;
      end
    end else if (abort) begin
      state <= S_IDLE;
    end else if (xfer) begin
      case (state)
        S_RD1: begin first_tog <= bus_rdata[TOG_BIT]; state <= S_RD2; end
        S_CF1: begin first_tog <= bus_rdata[TOG_BIT]; state <= S_CF2; end
        S_RD2: begin
          if (!toggled) begin
            done <= 1'b1; fail <= 1'b0; state <= S_IDLE;
          end else if (bus_rdata[LIM_BIT]) begin
            state <= S_CF1;
          end else if (limit) begin
            state <= S_RST;
          end else begin
            polls <= polls + 1'b1;
            state <= S_RD1;
          end
        end
        S_CF2: begin
          if (!toggled) begin
            done <= 1'b1; fail <= 1'b0; state <= S_IDLE;
          end else begin
            state <= S_RST;
          end
        end
        S_RST: begin done <= 1'b1; fail <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r9_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack && !abort) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  a_r5_write_is_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we) |-> (bus_wdata == RESET_CMD));

  a_r5_fail_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(bus_req && bus_we && bus_ack));

  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(fail)));

  a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !bus_req) |=> (!done && !fail && bus_req));

  a_r7_abort_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && bus_req) |=> (!bus_req && !done));

  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !bus_req);

  a_r5_fail_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);

endmodule

// File: tb/flash_toggle_poller_bench.sv
`timescale 1ns/1ps
module flash_toggle_poller_bench;
  logic        clk = 0, rst_n = 0, start = 0, abort = 0;
  logic [23:0] status_addr = 24'h00_0AAA;
  logic [15:0] max_polls = 16'd20;
  logic        bus_req, bus_we, done, fail;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata = 0;
  logic        bus_ack = 0;

  int total = 0, bad = 0, cyc = 0;

  // flash stub
  logic s_tog = 0, s_b5 = 0;
  int   s_left = 0, s_reads = 0, s_writes = 0;

  // reference model
  int          m_ph = 0, m_n = 0, m_max = 1;
  logic        m_done = 0, m_fail = 0, m_first = 0;
  logic [23:0] m_addr = 0;

  always #4 clk = ~clk;

  flash_toggle_poller u_flash_toggle_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
    .status_addr(status_addr), .max_polls(max_polls),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .done(done), .fail(fail));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && bus_req && bus_ack && !abort) begin
      if (bus_we) s_writes++;
      else begin
        s_reads++;
        if (s_left > 0) begin s_tog = ~s_tog; s_left--; end
      end
    end
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_fail = 0;
    end else if (m_ph == 0) begin
      if (start) begin
        m_ph = 1; m_done = 0; m_fail = 0; m_n = 0;
        m_max = (max_polls == 0) ? 1 : int'(max_polls);
        m_addr = status_addr;
      end
    end else if (abort) begin
      m_ph = 0;
    end else if (bus_ack) begin
      case (m_ph)
        1: begin m_first = bus_rdata[6]; m_ph = 2; end
        3: begin m_first = bus_rdata[6]; m_ph = 4; end
        2: if (bus_rdata[6] == m_first) begin m_done = 1; m_fail = 0; m_ph = 0; end
           else if (bus_rdata[5]) m_ph = 3;
           else begin m_n++; m_ph = (m_n >= m_max) ? 5 : 1; end
        4: if (bus_rdata[6] == m_first) begin m_done = 1; m_fail = 0; m_ph = 0; end
           else m_ph = 5;
        5: begin m_done = 1; m_fail = 1; m_ph = 0; end
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk(done == m_done, "R8 done", done, m_done);
      chk(fail == m_fail, "R8 fail", fail, m_fail);
      chk(bus_req == (m_ph != 0), "R9 bus_req", bus_req, m_ph != 0);
      if (bus_req) begin
        chk(bus_we == (m_ph == 5), "R5 bus_we", bus_we, m_ph == 5);
        if (!bus_we) chk(bus_addr == m_addr, "R2 bus_addr", bus_addr, m_addr);
        else chk(bus_wdata == 8'hF0, "R5 bus_wdata", bus_wdata, 8'hF0);
      end
    end
    bus_ack   = bus_req && !bus_ack;
    bus_rdata = {1'b0, s_tog, s_b5, 5'b0};
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic run_case(input int left, input logic b5, input int maxp,
                          input int exp_reads, input int exp_writes,
                          input logic exp_fail, input string tag);
    @(negedge clk);
    s_left = left; s_b5 = b5; max_polls = 16'(maxp);
    s_reads = 0; s_writes = 0;
    status_addr = status_addr + 24'h10;
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(s_reads == exp_reads, {tag, " reads"}, s_reads, exp_reads);
    chk(s_writes == exp_writes, {tag, " writes"}, s_writes, exp_writes);
    chk(fail == exp_fail, {tag, " fail"}, fail, exp_fail);
    chk(done == 1, {tag, " done"}, done, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(bus_req == 0, "R1 bus_req", bus_req, 0);
    chk(done == 0, "R1 done", done, 0);
    chk(fail == 0, "R1 fail", fail, 0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk(bus_req == 0 && done == 0, "R1 idle after reset", bus_req, 0);

    run_case(0, 0, 20, 2, 0, 0, "R2 stopped");
    run_case(5, 0, 20, 8, 0, 0, "R3 late stop");
    run_case(1, 1, 20, 4, 0, 0, "R4 confirm stops");
    run_case(1000, 1, 20, 4, 1, 1, "R5 confirm toggles");

    repeat (20) @(negedge clk);
    chk(done == 1 && fail == 1, "R8 held", {done, fail}, 3);

    run_case(1000, 0, 3, 6, 1, 1, "R6 limit");
    run_case(1000, 0, 0, 2, 1, 1, "R6 limit zero");

    // R10: start pulses while busy are ignored
    @(negedge clk);
    s_left = 5; s_b5 = 0; max_polls = 20; s_reads = 0; s_writes = 0;
    pulse_start();
    repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;
    wait_done();
    @(negedge clk);
    chk(s_reads == 8, "R10 reads", s_reads, 8);
    chk(fail == 0, "R10 fail", fail, 0);

    // R7: abort, then restart with fresh pair
    @(negedge clk);
    s_left = 1000; s_b5 = 0; max_polls = 100; s_reads = 0; s_writes = 0;
    pulse_start();
    repeat (9) @(negedge clk);
    abort = 1; @(negedge clk); abort = 0;
    chk(bus_req == 0, "R7 req dropped", bus_req, 0);
    chk(done == 0, "R7 no done", done, 0);
    repeat (5) @(negedge clk);
    chk(bus_req == 0 && done == 0, "R7 stays idle", bus_req, 0);
    s_left = 0; s_reads = 0;
    pulse_start();
    wait_done();
    @(negedge clk);
    chk(s_reads == 2, "R7 restart reads", s_reads, 2);
    chk(fail == 0, "R7 restart ok", fail, 0);

    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule